// File: doc/BRIEF.md
# Step/Direction Stepper Phase Indexer

This block converts a step pulse and a direction level into the four low-side phase enables of a unipolar stepper motor. Every rising edge of the step input moves an internal position index by one place. The direction level, sampled at that edge, decides whether the index moves forward (clockwise) or backward (counter-clockwise). A phase table turns the index into the four coil enables. A 2-bit mode input picks one of three tables: two coils on at a time (full step), alternating one and two coils (half step), or one coil at a time (wave drive).

Each table has a home position, index 0. An active-low flag marks it. A synchronous active-high indexer reset moves the index back to home. A fault hold input from the protection logic freezes the index. An active-low output enable blanks the coil outputs while the index keeps counting. The step and direction inputs are asynchronous to the clock and pass through two-flop synchronizers. The mode and hold inputs are treated as quasi-static levels. The system reset `rst_n` is asserted asynchronously and is assumed to be released in step with `clk`.

Top module: `stepper_indexer`

## Requirements
- R1: With mode 2'b00 (full step), phase bits [3:0] (bit 0 = coil 1) follow the index as 0:1001, 1:0011, 2:0110, 3:1100.
- R2: With mode 2'b01 (half step), the phase bits follow an 8-position cycle: 0:0001, 1:0011, 2:0010, 3:0110, 4:0100, 5:1100, 6:1000, 7:1001.
- R3: With mode 2'b10 (wave drive), the phase bits follow 0:0001, 1:0010, 2:0100, 3:1000.
- R4: A step edge with `dir_in`=1 raises the index by one and with `dir_in`=0 lowers it by one. The index wraps from the last position to 0 and from 0 to the last position.
- R5: `at_home_n` is 0 exactly when the index is at position 0, and 1 otherwise.
- R6: While `idx_rst` is 1, the index is forced to 0 and step edges are ignored.
- R7: While `oe_n` is 1, all phase bits are 0, yet step edges still move the index, as seen once `oe_n` returns to 0.
- R8: While `fault_hold` is 1, step edges are ignored and the index keeps its value.
- R9: With mode 2'b11 (reserved), all phase bits are 0 and step edges are ignored.
- R10: Any change of the mode input returns the index to 0 on the next clock edge.
- R11: A rising edge on `step_in` changes the outputs on the third rising clock edge after it is applied, and not before. A step input that stays high gives exactly one move.
- R12: Assertion of `rst_n` puts the index at 0 and the mode at full step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| idx_rst | input | 1 | Synchronous active-high indexer reset to home |
| step_in | input | 1 | Step pulse, asynchronous, rising edge counts |
| dir_in | input | 1 | Direction, 1 = forward, asynchronous |
| mode | input | 2 | Excitation mode: 00 full, 01 half, 10 wave, 11 reserved |
| oe_n | input | 1 | Active-low output enable |
| fault_hold | input | 1 | Freezes the index while high |
| phase | output | 4 | Coil enables, bit 0 = coil 1 |
| at_home_n | output | 1 | Low while the index is at home |

## Verification
Directed walks cover every position of each of the three tables in both directions, including both wrap points. This separates a wrong table entry from a wrong step direction or wrap limit. A long high step pulse is checked at the second and third clock edges after it is applied, which pins down the synchronizer latency and confirms that one level gives one move. Random sequences then mix direction, output blanking, hold, indexer reset and mode changes. They expose ordering mistakes between these controls, such as a mode change that fails to re-home, or a blanked output that also stalls the index.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  localparam int unsigned PH_W  = 4;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_HALF = 2'b01,
    MODE_WAVE = 2'b10,
    MODE_RSVD = 2'b11
  } step_mode_e;

  // rotate a 4-bit coil pattern left by n places
  function automatic logic [PH_W-1:0] rotl4(input logic [PH_W-1:0] v,
                                            input logic [1:0] n);
    logic [2*PH_W-1:0] dbl;
    dbl = {v, v} << n;
    return dbl[2*PH_W-1:PH_W];
  endfunction

  // coil pattern for a mode and index position
  function automatic logic [PH_W-1:0] coil_pattern(input step_mode_e m,
                                                   input logic [IDX_W-1:0] idx);
    logic [PH_W-1:0] one;
    case (m)
      MODE_FULL: coil_pattern = rotl4(4'b0011, idx[1:0] + 2'd3);
      MODE_HALF: begin
        one = rotl4(4'b0001, idx[2:1]);
        coil_pattern = idx[0] ? (one | rotl4(one, 2'd1)) : one;
      end
      MODE_WAVE: coil_pattern = rotl4(4'b0001, idx[1:0]);
      default:   coil_pattern = '0;
    endcase
  endfunction

endpackage

// File: rtl/stepper_sync.sv
module stepper_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/stepper_index.sv
module stepper_index #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv_en,
  input  logic             fwd,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr) begin
      idx_d = '0;
    end else if (adv_en) begin
      if (fwd) idx_d = (idx_q == last) ? '0 : idx_q + 1'b1;
      else     idx_d = (idx_q == '0) ? last : idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx = idx_q;

  // R8/R11: no move without an enabled advance or a clear
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv_en) |=> $stable(idx_q));

  // R6/R10: a clear always lands on home
  a_r10_clear_home: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx_q == '0));

  // R4: index never leaves the active table range
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && adv_en) |=> (idx_q <= $past(last)));

endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
  import stepper_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_rst,
  input  logic       step_in,
  input  logic       dir_in,
  input  logic [1:0] mode,
  input  logic       oe_n,
  input  logic       fault_hold,
  output logic [3:0] phase,
  output logic       at_home_n
);

  localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(2*PH_W - 1);
  localparam logic [IDX_W-1:0] LAST_QUAD = IDX_W'(PH_W - 1);

  logic [1:0]       sync_q;
  logic             step_s, dir_s, step_prev_q;
  logic             step_edge, mode_chg, adv_en, clr;
  step_mode_e       mode_q, mode_in;
  logic [IDX_W-1:0] idx, last;

  stepper_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dir_in, step_in}), .q(sync_q)
  );
  assign step_s = sync_q[0];
  assign dir_s  = sync_q[1];

  assign mode_in = step_mode_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_prev_q <= 1'b0;
      mode_q      <= MODE_FULL;
    end else begin
      step_prev_q <= step_s;
      mode_q      <= mode_in;
    end
  end

  always_comb begin
    step_edge = step_s & ~step_prev_q;
    mode_chg  = (mode_in != mode_q);
    clr       = idx_rst | mode_chg;
    adv_en    = step_edge & ~fault_hold & (mode_q != MODE_RSVD);
    last      = (mode_q == MODE_HALF) ? LAST_HALF : LAST_QUAD;
  end

  stepper_index #(.IDX_W(IDX_W)) u_index (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv_en(adv_en),
    .fwd(dir_s), .last(last), .idx(idx)
  );

  assign phase     = oe_n ? '0 : coil_pattern(mode_q, idx);
  assign at_home_n = |idx;

  // R1: full step always drives two coils
  a_r1_full_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && mode_q == MODE_FULL) |-> ($countones(phase) == 2));

  // R3: wave drive always drives one coil
  a_r3_wave_single: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && mode_q == MODE_WAVE) |-> ($countones(phase) == 1));

  // R2: half step drives one or two coils
  a_r2_half_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && mode_q == MODE_HALF) |-> ($countones(phase) inside {1, 2}));

  // R6: an indexer reset reports home on the next edge
  a_r6_reset_home: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rst |=> !at_home_n);

  // R8: hold freezes the home flag when no clear is present
  a_r8_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_hold && !idx_rst && !mode_chg) |=> $stable(at_home_n));

endmodule

// File: tb/stepper_indexer_test.sv
module stepper_indexer_test;

  logic       clk = 1'b0;
  logic       rst_n, idx_rst, step_in, dir_in, oe_n, fault_hold;
  logic [1:0] mode;
  logic [3:0] phase;
  logic       at_home_n;

  int errors = 0;
  int checks = 0;
  int m_idx  = 0;
  int m_mode = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  stepper_indexer uut (
    .clk(clk), .rst_n(rst_n), .idx_rst(idx_rst), .step_in(step_in),
    .dir_in(dir_in), .mode(mode), .oe_n(oe_n), .fault_hold(fault_hold),
    .phase(phase), .at_home_n(at_home_n)
  );

  function automatic int last_of(input int md);
    return (md == 1) ? 7 : 3;
  endfunction

  function automatic logic [3:0] exp_phase(input int md, input int ix, input logic off);
    logic [3:0] p;
    case (md)
      0: case (ix) 0: p = 4'b1001; 1: p = 4'b0011; 2: p = 4'b0110; default: p = 4'b1100; endcase
      1: case (ix)
           0: p = 4'b0001; 1: p = 4'b0011; 2: p = 4'b0010; 3: p = 4'b0110;
           4: p = 4'b0100; 5: p = 4'b1100; 6: p = 4'b1000; default: p = 4'b1001;
         endcase
      2: case (ix) 0: p = 4'b0001; 1: p = 4'b0010; 2: p = 4'b0100; default: p = 4'b1000; endcase
      default: p = 4'b0000;
    endcase
    return off ? 4'b0000 : p;
  endfunction

  function automatic int moved(input int md, input int ix, input logic d);
    if (md == 3) return ix;
    if (d) return (ix == last_of(md)) ? 0 : ix + 1;
    return (ix == 0) ? last_of(md) : ix - 1;
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " phase"}, phase, exp_phase(m_mode, m_idx, oe_n));
    check({req, " home"}, {3'b0, at_home_n}, {3'b0, (m_idx != 0)});
  endtask

  task automatic pulse(input logic d);
    dir_in  = d;
    step_in = 1'b1;
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic step_chk(input logic d, input string req);
    pulse(d);
    m_idx = moved(m_mode, m_idx, d);
    check_state(req);
  endtask

  task automatic set_mode(input int md, input string req);
    mode = md[1:0];
    repeat (2) @(negedge clk);
    if (md != m_mode) m_idx = 0;
    m_mode = md;
    check_state(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; idx_rst = 1'b0; step_in = 1'b0; dir_in = 1'b0;
    oe_n = 1'b0; fault_hold = 1'b0; mode = 2'b00;
    repeat (3) @(negedge clk);
    check_state("R12 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_state("R12 after release");

    // R1/R4/R5: full step both ways and both wraps
    for (int i = 0; i < 5; i++) step_chk(1'b1, "R1 R4 full cw");
    for (int i = 0; i < 6; i++) step_chk(1'b0, "R4 R5 full ccw");

    // R11: latency and one move per level
    dir_in = 1'b1; step_in = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R11 not before third edge", phase, exp_phase(m_mode, m_idx, 1'b0));
    @(posedge clk);
    m_idx = moved(m_mode, m_idx, 1'b1);
    #1 check("R11 at third edge", phase, exp_phase(m_mode, m_idx, 1'b0));
    repeat (10) @(negedge clk);
    check_state("R11 held level single move");
    step_in = 1'b0;
    repeat (4) @(negedge clk);

    // R10/R2: mode change re-homes, then half step walk
    set_mode(1, "R10 to half");
    for (int i = 0; i < 9; i++) step_chk(1'b1, "R2 half cw");
    for (int i = 0; i < 3; i++) step_chk(1'b0, "R2 half ccw");

    // R3: wave drive
    set_mode(2, "R10 to wave");
    for (int i = 0; i < 5; i++) step_chk(1'b1, "R3 wave cw");
    for (int i = 0; i < 2; i++) step_chk(1'b0, "R3 wave ccw");

    // R9: reserved mode
    set_mode(3, "R9 reserved");
    step_chk(1'b1, "R9 step ignored");
    set_mode(0, "R9 back to full");

    // R7: outputs off, index still runs
    oe_n = 1'b1;
    step_chk(1'b1, "R7 blanked");
    step_chk(1'b1, "R7 blanked");
    oe_n = 1'b0;
    @(negedge clk);
    check_state("R7 index advanced while blanked");

    // R8: hold ignores steps
    fault_hold = 1'b1;
    pulse(1'b1);
    check_state("R8 hold");
    fault_hold = 1'b0;
    @(negedge clk);

    // R6: indexer reset with a step in flight
    idx_rst = 1'b1;
    pulse(1'b1);
    m_idx = 0;
    check_state("R6 reset ignores step");
    idx_rst = 1'b0;
    @(negedge clk);

    // mixed random sequences
    for (int it = 0; it < 400; it++) begin
      int r;
      r = $urandom % 16;
      if ($urandom % 8 == 0) oe_n = ~oe_n;
      if (r == 0) begin
        set_mode($urandom % 4, "R10 random mode");
      end else if (r == 1) begin
        idx_rst = 1'b1;
        pulse($urandom % 2);
        m_idx = 0;
        idx_rst = 1'b0;
        @(negedge clk);
        check_state("R6 random reset");
      end else if (r == 2) begin
        fault_hold = 1'b1;
        pulse($urandom % 2);
        fault_hold = 1'b0;
        @(negedge clk);
        check_state("R8 random hold");
      end else begin
        step_chk($urandom % 2, "R4 R7 random step");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule